// File: doc/BRIEF.md
# Paged Address Translator with Write Protection

This block turns a logical address into a physical address for a paged memory. The upper bits of the logical address select a page and the lower bits are an offset that passes through untouched. The page number is first looked up in a small fully associative translation cache. On a hit the frame number comes from the cache. On a miss the block spends one extra cycle reading a page table held in local registers, and writes the entry into the cache in round-robin order. The physical address is the frame number placed above the offset.

Each page-table entry also holds a protection bit. A write request to a read-only page produces a trap pulse instead of a translation. The protection bit is always taken from the page table, so a protection change takes effect at once even for pages already held in the cache. A frame change in the page table reaches the cache only after the cache is flushed. A requester presents one request per cycle while `reqReady` is high. The page table is loaded through a simple write port.

Top module: `page_xlat`

## Requirements
- R1: `physAddr` equals `{frame, offset}`: the low `OFF_W` bits are the request's offset unchanged and the upper `FRAME_W` bits are the page's frame number.
- R2: A page-table write with `ptWrEn` high stores `ptWrFrame` and `ptWrRw` for page `ptWrPage`. Later misses to that page return the stored frame.
- R3: On a cache miss `reqReady` drops for exactly one cycle. The response appears two clock edges after the request with `tlbHit`=0. The page is then in the cache, so a following request to it hits.
- R4: On a cache hit the response appears on the next clock edge with `tlbHit`=1, and `reqReady` stays high.
- R5: Protection bit 1 means read-write and 0 means read-only. A write to a read-only page gives `trap`=1, `valid`=0 and `physAddr`=0 for one cycle in the response slot. Reads of read-only pages translate normally.
- R6: The protection check uses the page table's current bit on hits and on misses, so a protection change applies to cached pages without a flush.
- R7: A cached frame stays in use after its page-table entry changes, until a flush. The first request after the flush misses and returns the new frame.
- R8: `flush` invalidates every cache entry. A request accepted in the same cycle as `flush` is treated as a miss, and `tlbHit` is 0 in the cycle after any flush.
- R9: With `TLB_DEPTH` entries full, each new miss overwrites the slots in round-robin order, starting from slot 0 after reset.
- R10: After reset `valid`, `trap`, `tlbHit` and `physAddr` are 0 and `reqReady` is 1. The cache is empty and every page-table entry is frame 0, read-only.
- R11: `valid` and `trap` are never high together, and `tlbHit` is high only in a response cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Translation request, accepted when `reqReady` is high |
| reqWrite | input | 1 | Request is a write (1) or a read (0) |
| logAddr | input | LA_W | Logical address of the request |
| reqReady | output | 1 | Block can accept a request this cycle |
| flush | input | 1 | Invalidate all cache entries |
| ptWrEn | input | 1 | Page-table entry write strobe |
| ptWrPage | input | LA_W-OFF_W | Page-table entry index |
| ptWrFrame | input | FRAME_W | Frame number to store |
| ptWrRw | input | 1 | Protection bit to store (1 read-write, 0 read-only) |
| physAddr | output | FRAME_W+OFF_W | Translated physical address |
| valid | output | 1 | `physAddr` holds a translation this cycle |
| tlbHit | output | 1 | The response came from the cache |
| trap | output | 1 | Write to a read-only page was refused |

## Verification
The assertions assume that `reqValid` is raised only while `reqReady` is high and that `logAddr` and `reqWrite` stay steady through the accepting cycle. The offset check on hits compares against the address of the previous cycle, and the one-cycle stall check assumes no request arrives while the block is refilling. The stimulus waits until `reqReady` is high before each request, drives every input at the falling edge, and removes `reqValid` right after the accepting edge, so both assumptions hold.

// File: rtl/page_xlat_pkg.sv
package page_xlat_pkg;

  typedef enum logic {
    ST_IDLE   = 1'b0,
    ST_REFILL = 1'b1
  } xlatState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic acceptHit;  // request accepted and served from the cache
    logic startMiss;  // request accepted, capture it for refill
    logic doRefill;   // read page table, install, respond
    logic doFlush;    // clear every cache entry
  } xlatStrobe_t;

endpackage

// File: rtl/page_xlat_ctrl.sv
module page_xlat_ctrl
  import page_xlat_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        flush,
  input  logic        lookupHit,
  output logic        reqReady,
  output xlatStrobe_t strb
);

  xlatState_t state;
  logic       idleReq;
  logic       usableHit;

  assign reqReady  = (state == ST_IDLE);
  assign idleReq   = reqReady && reqValid;
  // a flush in the same cycle wins over the lookup
  assign usableHit = lookupHit && !flush;

  always_comb begin
    strb           = '0;
    strb.acceptHit = idleReq && usableHit;
    strb.startMiss = idleReq && !usableHit;
    strb.doRefill  = (state == ST_REFILL);
    strb.doFlush   = flush;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
    end else begin
      case (state)
        ST_IDLE:   if (strb.startMiss) state <= ST_REFILL;
        ST_REFILL: state <= ST_IDLE;
        default:   state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/page_xlat_dp.sv
module page_xlat_dp
  import page_xlat_pkg::*;
#(
  parameter int LA_W      = 16,
  parameter int OFF_W     = 12,
  parameter int FRAME_W   = 8,
  parameter int TLB_DEPTH = 64,
  localparam int PN_W     = LA_W - OFF_W,
  localparam int PAGES    = 1 << PN_W,
  localparam int PA_W     = FRAME_W + OFF_W,
  localparam int VIC_W    = $clog2(TLB_DEPTH)
) (
  input  logic               clk,
  input  logic               rstN,
  input  xlatStrobe_t        strb,
  input  logic               reqWrite,
  input  logic [LA_W-1:0]    logAddr,
  input  logic               ptWrEn,
  input  logic [PN_W-1:0]    ptWrPage,
  input  logic [FRAME_W-1:0] ptWrFrame,
  input  logic               ptWrRw,
  output logic               lookupHit,
  output logic [PA_W-1:0]    physAddr,
  output logic               valid,
  output logic               tlbHit,
  output logic               trap
);

  // page table
  logic [FRAME_W-1:0] ptFrame [PAGES];
  logic [PAGES-1:0]   ptRw;

  // translation cache
  logic [TLB_DEPTH-1:0] tlbValid;
  logic [PN_W-1:0]      tlbTag   [TLB_DEPTH];
  logic [FRAME_W-1:0]   tlbFrame [TLB_DEPTH];
  logic [VIC_W-1:0]     victim;

  logic [TLB_DEPTH-1:0] matchVec;
  logic [FRAME_W-1:0]   maskedFrame [TLB_DEPTH];
  logic [FRAME_W-1:0]   hitFrame;

  logic [PN_W-1:0]  inPage;
  logic [OFF_W-1:0] inOff;
  logic [PN_W-1:0]  pendPage;
  logic [OFF_W-1:0] pendOff;
  logic             pendWrite;
  logic             installNow;

  assign inPage = logAddr[LA_W-1:OFF_W];
  assign inOff  = logAddr[OFF_W-1:0];

  // parallel compare against every key
  for (genvar g = 0; g < TLB_DEPTH; g++) begin : gCmp
    assign matchVec[g]    = tlbValid[g] && (tlbTag[g] == inPage);
    assign maskedFrame[g] = matchVec[g] ? tlbFrame[g] : '0;
  end

  always_comb begin
    hitFrame = '0;
    for (int i = 0; i < TLB_DEPTH; i++) hitFrame = hitFrame | maskedFrame[i];
  end

  assign lookupHit  = |matchVec;
  assign installNow = strb.doRefill && !strb.doFlush;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < PAGES; i++) ptFrame[i] <= '0;
      ptRw <= '0;
    end else if (ptWrEn) begin
      ptFrame[ptWrPage] <= ptWrFrame;
      ptRw[ptWrPage]    <= ptWrRw;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendPage  <= '0;
      pendOff   <= '0;
      pendWrite <= 1'b0;
    end else if (strb.startMiss) begin
      pendPage  <= inPage;
      pendOff   <= inOff;
      pendWrite <= reqWrite;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tlbValid <= '0;
      victim   <= '0;
    end else if (strb.doFlush) begin
      tlbValid <= '0;
    end else if (installNow) begin
      tlbValid[victim] <= 1'b1;
      victim <= (victim == VIC_W'(TLB_DEPTH - 1)) ? '0 : victim + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (installNow) begin
      tlbTag[victim]   <= pendPage;
      tlbFrame[victim] <= ptFrame[pendPage];
    end
  end

  // registered response
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      valid    <= 1'b0;
      trap     <= 1'b0;
      tlbHit   <= 1'b0;
      physAddr <= '0;
    end else begin
      valid    <= 1'b0;
      trap     <= 1'b0;
      tlbHit   <= 1'b0;
      physAddr <= '0;
      if (strb.acceptHit) begin
        tlbHit <= 1'b1;
        if (reqWrite && !ptRw[inPage]) begin
          trap <= 1'b1;
        end else begin
          valid    <= 1'b1;
          physAddr <= {hitFrame, inOff};
        end
      end else if (strb.doRefill) begin
        if (pendWrite && !ptRw[pendPage]) begin
          trap <= 1'b1;
        end else begin
          valid    <= 1'b1;
          physAddr <= {ptFrame[pendPage], pendOff};
        end
      end
    end
  end

endmodule

// File: rtl/page_xlat.sv
module page_xlat
  import page_xlat_pkg::*;
#(
  parameter int LA_W      = 16,
  parameter int OFF_W     = 12,
  parameter int FRAME_W   = 8,
  parameter int TLB_DEPTH = 64
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      reqValid,
  input  logic                      reqWrite,
  input  logic [LA_W-1:0]           logAddr,
  output logic                      reqReady,
  input  logic                      flush,
  input  logic                      ptWrEn,
  input  logic [LA_W-OFF_W-1:0]     ptWrPage,
  input  logic [FRAME_W-1:0]        ptWrFrame,
  input  logic                      ptWrRw,
  output logic [FRAME_W+OFF_W-1:0]  physAddr,
  output logic                      valid,
  output logic                      tlbHit,
  output logic                      trap
);

  xlatStrobe_t strb;
  logic        lookupHit;

  page_xlat_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .reqValid  (reqValid),
    .flush     (flush),
    .lookupHit (lookupHit),
    .reqReady  (reqReady),
    .strb      (strb)
  );

  page_xlat_dp #(
    .LA_W      (LA_W),
    .OFF_W     (OFF_W),
    .FRAME_W   (FRAME_W),
    .TLB_DEPTH (TLB_DEPTH)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .reqWrite  (reqWrite),
    .logAddr   (logAddr),
    .ptWrEn    (ptWrEn),
    .ptWrPage  (ptWrPage),
    .ptWrFrame (ptWrFrame),
    .ptWrRw    (ptWrRw),
    .lookupHit (lookupHit),
    .physAddr  (physAddr),
    .valid     (valid),
    .tlbHit    (tlbHit),
    .trap      (trap)
  );

endmodule

// File: rtl/page_xlat_chk.sv
module page_xlat_chk #(
  parameter int LA_W    = 16,
  parameter int OFF_W   = 12,
  parameter int FRAME_W = 8
) (
  input logic                     clk,
  input logic                     rstN,
  input logic                     reqReady,
  input logic                     flush,
  input logic [LA_W-1:0]          logAddr,
  input logic [FRAME_W+OFF_W-1:0] physAddr,
  input logic                     valid,
  input logic                     tlbHit,
  input logic                     trap
);

  assert_valid_trap_excl_R11: assert property (@(posedge clk) disable iff (!rstN)
    !(valid && trap));

  assert_hit_in_response_R11: assert property (@(posedge clk) disable iff (!rstN)
    tlbHit |-> (valid || trap));

  assert_refill_one_cycle_R3: assert property (@(posedge clk) disable iff (!rstN)
    !reqReady |=> (reqReady && (valid || trap) && !tlbHit));

  assert_hit_no_stall_R4: assert property (@(posedge clk) disable iff (!rstN)
    tlbHit |-> reqReady);

  assert_offset_kept_R1: assert property (@(posedge clk) disable iff (!rstN)
    (valid && tlbHit) |-> (physAddr[OFF_W-1:0] == $past(logAddr[OFF_W-1:0])));

  assert_trap_no_addr_R5: assert property (@(posedge clk) disable iff (!rstN)
    trap |-> (physAddr == '0));

  assert_flush_kills_hit_R8: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> !tlbHit);

endmodule

bind page_xlat page_xlat_chk #(
  .LA_W    (LA_W),
  .OFF_W   (OFF_W),
  .FRAME_W (FRAME_W)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .reqReady (reqReady),
  .flush    (flush),
  .logAddr  (logAddr),
  .physAddr (physAddr),
  .valid    (valid),
  .tlbHit   (tlbHit),
  .trap     (trap)
);

// File: tb/page_xlat_bench.sv
`timescale 1ns/1ps
module page_xlat_bench;

  localparam int LA_W    = 16;
  localparam int OFF_W   = 12;
  localparam int FRAME_W = 8;
  localparam int DEPTH   = 4;
  localparam int PN_W    = LA_W - OFF_W;
  localparam int PA_W    = FRAME_W + OFF_W;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0, reqWrite = 1'b0, flush = 1'b0;
  logic [LA_W-1:0] logAddr = '0;
  logic ptWrEn = 1'b0, ptWrRw = 1'b0;
  logic [PN_W-1:0] ptWrPage = '0;
  logic [FRAME_W-1:0] ptWrFrame = '0;
  logic reqReady, valid, tlbHit, trap;
  logic [PA_W-1:0] physAddr;

  int checks = 0;
  int errors = 0;

  logic [PA_W-1:0] gotPhys;
  logic gotValid, gotHit, gotTrap, gotMiss;

  always #2.5 clk = ~clk;

  page_xlat #(
    .LA_W(LA_W), .OFF_W(OFF_W), .FRAME_W(FRAME_W), .TLB_DEPTH(DEPTH)
  ) u_page_xlat (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .logAddr(logAddr), .reqReady(reqReady), .flush(flush), .ptWrEn(ptWrEn),
    .ptWrPage(ptWrPage), .ptWrFrame(ptWrFrame), .ptWrRw(ptWrRw),
    .physAddr(physAddr), .valid(valid), .tlbHit(tlbHit), .trap(trap)
  );

  // {write, logical address, expected physical, expected hit, expected trap}
  // frames programmed as 0x40 + 3*page, odd pages read-write
  localparam int NVEC = 13;
  localparam logic [38:0] VEC [NVEC] = '{
    {1'b0, 16'h1234, 20'h43234, 1'b0, 1'b0},
    {1'b0, 16'h1ABC, 20'h43ABC, 1'b1, 1'b0},
    {1'b1, 16'h1000, 20'h43000, 1'b1, 1'b0},
    {1'b1, 16'h2010, 20'h00000, 1'b0, 1'b1},
    {1'b0, 16'h2FFF, 20'h46FFF, 1'b1, 1'b0},
    {1'b1, 16'h2FFF, 20'h00000, 1'b1, 1'b1},
    {1'b0, 16'h0000, 20'h40000, 1'b0, 1'b0},
    {1'b0, 16'hF001, 20'h6D001, 1'b0, 1'b0},
    {1'b0, 16'h3456, 20'h49456, 1'b0, 1'b0},
    {1'b0, 16'h2123, 20'h46123, 1'b1, 1'b0},
    {1'b0, 16'h1777, 20'h43777, 1'b0, 1'b0},
    {1'b0, 16'h2000, 20'h46000, 1'b0, 1'b0},
    {1'b0, 16'hF0F0, 20'h6D0F0, 1'b1, 1'b0}
  };

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic ptWrite(input int page, input int frame, input bit rw);
    @(negedge clk);
    ptWrEn = 1'b1; ptWrPage = PN_W'(page); ptWrFrame = FRAME_W'(frame); ptWrRw = rw;
    @(negedge clk);
    ptWrEn = 1'b0;
  endtask

  task automatic doFlush();
    @(negedge clk);
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
  endtask

  task automatic doReq(input bit wr, input logic [LA_W-1:0] addr, input bit withFlush);
    @(negedge clk);
    while (!reqReady) @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; logAddr = addr; flush = withFlush;
    @(negedge clk);
    reqValid = 1'b0; flush = 1'b0;
    gotMiss = !reqReady;
    if (gotMiss) @(negedge clk);
    gotPhys = physAddr; gotValid = valid; gotHit = tlbHit; gotTrap = trap;
  endtask

  task automatic expectResp(input string tag, input logic [PA_W-1:0] ePhys,
                            input bit eHit, input bit eTrap);
    check(gotPhys == ePhys, {tag, " physAddr"}, 32'(gotPhys), 32'(ePhys));
    check(gotHit == eHit, {tag, " tlbHit"}, 32'(gotHit), 32'(eHit));
    check(gotMiss == !eHit, {tag, " stall"}, 32'(gotMiss), 32'(!eHit));
    check(gotTrap == eTrap, {tag, " trap"}, 32'(gotTrap), 32'(eTrap));
    check(gotValid == !eTrap, {tag, " valid"}, 32'(gotValid), 32'(!eTrap));
  endtask

  initial begin
    #(5ns * 100000);
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    check(valid == 1'b0 && trap == 1'b0 && tlbHit == 1'b0, "R10 flags in reset",
          32'({valid, trap, tlbHit}), 32'h0);
    rstN = 1'b1;
    @(negedge clk);
    check(physAddr == '0, "R10 physAddr after reset", 32'(physAddr), 32'h0);
    check(reqReady == 1'b1, "R10 ready after reset", 32'(reqReady), 32'h1);
    // R10: empty cache, page table frame 0 and read-only
    doReq(1'b0, 16'h5123, 1'b0);
    expectResp("R10 read after reset", 20'h00123, 1'b0, 1'b0);
    doReq(1'b1, 16'h6000, 1'b0);
    expectResp("R10 write read-only after reset", 20'h00000, 1'b0, 1'b1);
    doFlush();

    // R2: program the page table
    for (int p = 0; p < 16; p++) ptWrite(p, 8'h40 + 3 * p, p[0]);

    // R1 R3 R4 R5 R9: vector walk
    for (int i = 0; i < NVEC; i++) begin
      doReq(VEC[i][38], VEC[i][37:22], 1'b0);
      expectResp($sformatf("R1 R3 R4 R5 R9 vector %0d", i), VEC[i][21:2], VEC[i][1], VEC[i][0]);
    end

    // R6: protection change applies to a cached page
    ptWrite(15, 8'h6D, 1'b0);
    doReq(1'b1, 16'hF000, 1'b0);
    expectResp("R6 write after protect", 20'h00000, 1'b1, 1'b1);

    // R7: stale frame until flush
    ptWrite(15, 8'h77, 1'b1);
    doReq(1'b0, 16'hF008, 1'b0);
    expectResp("R7 stale frame", 20'h6D008, 1'b1, 1'b0);
    doFlush();
    doReq(1'b0, 16'hF008, 1'b0);
    expectResp("R7 new frame after flush", 20'h77008, 1'b0, 1'b0);

    // R8: request together with flush is a miss
    doReq(1'b0, 16'h3000, 1'b0);
    expectResp("R8 fill page 3", 20'h49000, 1'b0, 1'b0);
    doReq(1'b0, 16'h3004, 1'b1);
    expectResp("R8 request with flush", 20'h49004, 1'b0, 1'b0);
    doReq(1'b0, 16'h3008, 1'b0);
    expectResp("R8 refilled after flush", 20'h49008, 1'b1, 1'b0);

    // R11: idle outputs stay quiet
    @(negedge clk);
    check(!valid && !trap && !tlbHit, "R11 idle outputs", 32'({valid, trap, tlbHit}), 32'h0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule